// File: doc/BRIEF.md
# USB Line State Classifier

This block watches the two data lines of a low/full-speed USB link, sampled by a fast system clock. It passes each line through a two-flop synchronizer. It then reports the bus symbol every cycle: single-ended zero, single-ended one, J or K. J and K swap meaning with the link speed, so the classification follows a speed mode input. In automatic mode it follows the speed the block has detected itself.

While the link sits in single-ended zero, a counter times the condition. When the lines leave it, the block fires one of two single-cycle events: a bus reset for a long zero, or a low-speed keep-alive for a medium one. In automatic mode, the level the lines settle to after the zero selects full or low speed. Recovering bits and decoding packets are left to later stages.

Top module: `usb_line_classifier`

## Requirements
- R1: In every mode, both lines low gives symbol code 2 (SE0) and both lines high gives code 3 (SE1).
- R2: In mode 1 (full speed), D+ high with D- low gives code 0 (J), and D+ low with D- high gives code 1 (K). `low_rate` is 0.
- R3: In mode 2 (low speed), the J and K codes are swapped relative to R2. `low_rate` is 1.
- R4: In mode 3 (low bit rate with full-speed polarity), J and K decode as in R2 while `low_rate` is 1.
- R5: In mode 0 (automatic), leaving SE0 to D+ high selects full speed and leaving it to D- high selects low speed. From that cycle on, `low_rate` and the J/K mapping follow the selected speed.
- R6: Leaving an SE0 that lasted more than RESET_NS (312 cycles at the defaults) raises `bus_reset` for exactly one cycle, and does not raise `keep_alive`.
- R7: When the effective speed is low (mode 2, or mode 0 with low speed detected), leaving an SE0 that lasted more than KEEPALIVE_NS (150 cycles) and at most RESET_NS raises `keep_alive` for exactly one cycle. A shorter SE0 raises nothing.
- R8: In modes 1 and 3, and in mode 0 with full speed detected, a medium-length SE0 raises no event.
- R9: After reset, `sym` is J (code 0), mode 0 reports `low_rate` 0, and no event is raised.
- R10: A change on the lines appears on `sym` on the third rising clock edge after it is applied. An event appears on the same edge as the symbol that ends the SE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| dp_in | input | 1 | D+ line, asynchronous |
| dm_in | input | 1 | D- line, asynchronous |
| mode | input | 2 | 0 automatic, 1 full, 2 low, 3 low rate with full-speed polarity |
| sym | output | 2 | 0 J, 1 K, 2 SE0, 3 SE1 |
| low_rate | output | 1 | Link runs at the low bit rate |
| bus_reset | output | 1 | One-cycle pulse on leaving a long SE0 |
| keep_alive | output | 1 | One-cycle pulse on leaving a medium SE0 at low speed |

## Verification
A line change is due on `sym` three rising edges after it is driven: two synchronizer stages and the symbol register. An SE0 driven for N edges is counted as exactly N cycles. Its event is due three edges after the exit level is driven, on the same edge as the new symbol, and must be gone one edge later. Every check drives at a falling edge, waits the stated number of rising edges, and samples one nanosecond after the last one. The latency check also samples after two edges to confirm that the old symbol is still present there.

// File: rtl/usb_line_classifier.sv
module usb_line_classifier #(
  parameter int unsigned CLK_HZ       = 125_000_000,
  parameter int unsigned RESET_NS     = 2500,
  parameter int unsigned KEEPALIVE_NS = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_in,
  input  logic       dm_in,
  input  logic [1:0] mode,
  output logic [1:0] sym,
  output logic       low_rate,
  output logic       bus_reset,
  output logic       keep_alive
);

  localparam longint unsigned RST_L = (longint'(CLK_HZ) * RESET_NS) / 1_000_000_000;
  localparam longint unsigned KA_L  = (longint'(CLK_HZ) * KEEPALIVE_NS) / 1_000_000_000;
  localparam int unsigned RST_CYC = int'(RST_L);
  localparam int unsigned KA_CYC  = int'(KA_L);
  localparam int unsigned CW      = $clog2(RST_CYC + 2);
  localparam logic [CW-1:0] CMAX  = CW'(RST_CYC + 1);

  localparam logic [1:0] M_AUTO = 2'd0, M_FULL = 2'd1, M_LOW = 2'd2;
  localparam logic [1:0] S_J = 2'd0, S_K = 2'd1, S_SE0 = 2'd2, S_SE1 = 2'd3;

  logic [1:0]    dp_s, dm_s;
  logic [CW-1:0] cnt;
  logic          det_low, det_low_nxt;
  logic [1:0]    sym_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dp_s <= 2'b11;
      dm_s <= 2'b00;
    end else begin
      dp_s <= {dp_s[0], dp_in};
      dm_s <= {dm_s[0], dm_in};
    end

  wire p        = dp_s[1];
  wire m        = dm_s[1];
  wire se0      = ~p & ~m;
  wire leave    = ~se0 & (cnt != '0);
  wire long_se0 = cnt > CW'(RST_CYC);
  wire mid_se0  = (cnt > CW'(KA_CYC)) & ~long_se0;
  wire ls_now   = (mode == M_LOW) | ((mode == M_AUTO) & det_low);

  always_comb begin
    det_low_nxt = det_low;
    if (mode == M_AUTO && leave && (p ^ m)) det_low_nxt = m;
  end

  wire low_pol = (mode == M_LOW) | ((mode == M_AUTO) & det_low_nxt);

  always_comb begin
    if (se0)         sym_nxt = S_SE0;
    else if (p & m)  sym_nxt = S_SE1;
    else             sym_nxt = (p ^ low_pol) ? S_J : S_K;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt        <= '0;
      det_low    <= 1'b0;
      sym        <= S_J;
      bus_reset  <= 1'b0;
      keep_alive <= 1'b0;
    end else begin
      if (!se0)            cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
      det_low    <= det_low_nxt;
      sym        <= sym_nxt;
      bus_reset  <= leave & long_se0;
      keep_alive <= leave & mid_se0 & ls_now;
    end

  assign low_rate = (mode == M_FULL) ? 1'b0 : (mode == M_AUTO) ? det_low : 1'b1;

  a_r6_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);
  a_r7_ka_single: assert property (@(posedge clk) disable iff (!rst_n)
    keep_alive |=> !keep_alive);
  a_r6_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_reset && keep_alive));
  a_r10_event_ends_se0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset || keep_alive) |-> ($past(sym) == S_SE0 && sym != S_SE0));
  a_r1_se0_from_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (sym == S_SE0) |-> ($past(dp_in, 3) == 1'b0 && $past(dm_in, 3) == 1'b0));
  a_r8_full_no_ka: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FULL && $past(mode) == M_FULL) |-> !keep_alive);

endmodule

// File: tb/usb_line_classifier_bench.sv
module usb_line_classifier_bench;
  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b1, dm = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] sym;
  logic low_rate, bus_reset, keep_alive;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  usb_line_classifier u_usb_line_classifier (
    .clk(clk), .rst_n(rst_n), .dp_in(dp), .dm_in(dm), .mode(mode),
    .sym(sym), .low_rate(low_rate), .bus_reset(bus_reset), .keep_alive(keep_alive));

  // {mode[1:0], dp, dm, sym[1:0], low_rate}
  localparam int NV = 12;
  localparam logic [6:0] VEC [NV] = '{
    7'b01_10_00_0, 7'b01_01_01_0, 7'b01_00_10_0, 7'b01_11_11_0,
    7'b10_10_01_1, 7'b10_01_00_1, 7'b10_00_10_1, 7'b10_11_11_1,
    7'b11_10_00_1, 7'b11_01_01_1, 7'b11_00_10_1, 7'b11_11_11_1};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] md, input logic p, input logic m);
    @(negedge clk);
    mode = md; dp = p; dm = m;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic se0_exit(input string req, input int n, input logic p, input logic m,
                          input int exp_sym, input int exp_rst, input int exp_ka);
    @(negedge clk);
    dp = 1'b0; dm = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    dp = p; dm = m;
    settle();
    chk({req, " sym"}, sym, exp_sym);
    chk({req, " bus_reset"}, bus_reset, exp_rst);
    chk({req, " keep_alive"}, keep_alive, exp_ka);
    @(posedge clk); #1;
    chk({req, " pulse ends"}, bus_reset + keep_alive, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R9 reset sym", sym, 0);
    chk("R9 reset low_rate", low_rate, 0);
    chk("R9 reset events", bus_reset + keep_alive, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][6:5], VEC[i][4], VEC[i][3]);
      settle();
      chk($sformatf("R1-R4 vec%0d sym (R2 R3 R4 R1)", i), sym, VEC[i][2:1]);
      chk($sformatf("R2 R3 R4 vec%0d low_rate", i), low_rate, VEC[i][0]);
      chk($sformatf("R8 vec%0d events", i), bus_reset + keep_alive, 0);
    end

    drive(2'd1, 1'b1, 1'b0); settle();
    drive(2'd1, 1'b0, 1'b1);
    repeat (2) @(posedge clk); #1;
    chk("R10 old symbol at edge 2", sym, 0);
    @(posedge clk); #1;
    chk("R10 new symbol at edge 3", sym, 1);

    drive(2'd0, 1'b1, 1'b0); settle();
    se0_exit("R5 auto to low", 20, 1'b0, 1'b1, 0, 0, 0);
    chk("R5 low_rate low", low_rate, 1);
    drive(2'd0, 1'b1, 1'b0); settle();
    chk("R5 low polarity K", sym, 1);
    se0_exit("R7 auto low keep-alive", 200, 1'b0, 1'b1, 0, 0, 1);
    se0_exit("R5 auto to full", 20, 1'b1, 1'b0, 0, 0, 0);
    chk("R5 low_rate full", low_rate, 0);
    se0_exit("R8 auto full no keep-alive", 200, 1'b1, 1'b0, 0, 0, 0);

    drive(2'd2, 1'b0, 1'b1); settle();
    se0_exit("R7 150 cycles none", 150, 1'b0, 1'b1, 0, 0, 0);
    se0_exit("R7 151 cycles", 151, 1'b0, 1'b1, 0, 0, 1);
    se0_exit("R7 312 cycles", 312, 1'b0, 1'b1, 0, 0, 1);
    se0_exit("R6 313 cycles", 313, 1'b0, 1'b1, 0, 1, 0);

    drive(2'd1, 1'b1, 1'b0); settle();
    se0_exit("R8 full mode", 200, 1'b1, 1'b0, 0, 0, 0);
    se0_exit("R6 full long", 400, 1'b1, 1'b0, 0, 1, 0);
    drive(2'd3, 1'b1, 1'b0); settle();
    se0_exit("R8 mode3", 200, 1'b1, 1'b0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule